// File: doc/BRIEF.md
# Resistive Touchscreen Auto-Scan Sequencer

This block runs resistive touchscreen measurements on its own once software sets its enable bit. It steps through a fixed ring of panel phases. A settling wait comes before each of the two coordinate conversions. After the second conversion come three further programmable waits: a post-conversion delay, a touch-detect delay and an update (idle) delay. Every wait is a register value counted in cycles of the block's clock, which is normally a slow 32768 Hz clock. The conversions themselves go to an external converter through a simple request/acknowledge handshake. The current phase number is driven out so that the panel switch logic can configure the drive lines.

Each completed X/Y pair is packed with the pen state into a 32-bit word and pushed into a small sample queue. Software pops the queue through a register read, watches the empty and overrun flags in a status word, and gets an interrupt once one sample is waiting, or, in the four-sample mode, once four are waiting. Coordinate resolution can be reduced per axis, in which case the low result bits are forced to zero.

Top module: `tsc_autoscan`

## Requirements
- R1: After reset, phase is 0, adc_req and irq are low, the status word reads 0x80 (empty, no overrun) and the control word reads 0. The delay words read settle=2 at address 3, post=4 at address 4, touch=16 at address 5 and update=88 at address 6.
- R2: While control bit 0 (enable) is set, phase runs 1 settle-X, 2 convert-X, 3 settle-Y, 4 convert-Y, 5 post delay, 6 touch delay, 7 update delay, then 1 again. Phase 0 is idle.
- R3: A delay phase programmed with N lasts N cycles, and a value of 0 counts as 1. From the clock edge that accepts an X result to the edge that raises the Y request there are settle cycles. From the edge that accepts a Y result to the next X request there are post+touch+update+settle cycles.
- R4: adc_req stays high with adc_chan_y constant (0 for X, 1 for Y) until a cycle in which adc_ack is high, and adc_data is taken in that cycle. Requests alternate X then Y.
- R5: A queue word holds the inverse of pen_down at Y acceptance in bit 31, the X result in bits 25:16 and the Y result in bits 9:0. All other bits are 0.
- R6: Control bits 9:7 (X) and 6:4 (Y) hold a code n, and the result keeps 10-n bits: its lowest n bits are forced to 0. A code of 0 keeps all 10 bits.
- R7: A read of address 2 returns the oldest word and removes it. A read of address 2 while the queue is empty returns 0 and changes nothing. Status bit 7 is 1 exactly when the queue is empty.
- R8: The queue holds DEPTH (4) words. A sample finishing while the queue is full, with no pop in the same cycle, is dropped and sets status bit 8. The stored words stay as they are. Any read of status (address 0) clears bit 8 unless a drop happens in that same cycle.
- R9: With control bit 11 set, irq is high exactly while 4 or more words are queued. With it clear, irq is high while at least one word is queued.
- R10: Clearing the enable bit lets the current phase finish (a conversion in progress still completes and is queued), after which phase returns to 0 and no further request is raised. The queue is not flushed.
- R11: The control word reads back bits 0, 2, 4 to 9 and 11 as written, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (slow clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the queue or clears overrun) |
| reg_addr | input | 3 | Word address: 0 status, 1 control, 2 queue, 3 settle, 4 post, 5 touch, 6 update |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| adc_req | output | 1 | Conversion request |
| adc_chan_y | output | 1 | Requested axis: 0 X, 1 Y |
| adc_ack | input | 1 | Conversion done, adc_data valid |
| adc_data | input | 10 | Conversion result |
| pen_down | input | 1 | Touch detect level, 1 when touched |
| phase | output | 3 | Current phase number |
| irq | output | 1 | Sample-ready interrupt level |

## Verification
The hardest state to reach from the ports is the overrun corner: a Y result arriving into a full queue, either alone, which drops it, or in the same cycle as a pop, which keeps it. A directed pass shortens every delay and stops reading until the reference model records a drop. It then stops the scan and checks that the latched flag clears on the first status read and that the four stored words come out unchanged. Random rounds mix queue pops and status reads on every cycle with random converter latency, random delays including zero, and random resolutions, which makes the same-cycle pop and push come up naturally. Each converter handshake is timed against the programmed delays.

// File: rtl/tsc_autoscan.sv
`timescale 1ns/1ps
module tsc_autoscan #(
  parameter int DLY_W    = 16,
  parameter int DEPTH    = 4,
  parameter int RST_SETL = 2,
  parameter int RST_POST = 4,
  parameter int RST_TDET = 16,
  parameter int RST_UPD  = 88
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        adc_req,
  output logic        adc_chan_y,
  input  logic        adc_ack,
  input  logic [9:0]  adc_data,
  input  logic        pen_down,
  output logic [2:0]  phase,
  output logic        irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] IRQ4_CNT = CW'(4);
  localparam logic [2:0] A_STAT = 3'd0, A_CTRL = 3'd1, A_FIFO = 3'd2,
                         A_SETL = 3'd3, A_POST = 3'd4, A_TDET = 3'd5, A_UPD = 3'd6;

  typedef enum logic [2:0] {
    PH_OFF = 3'd0, PH_SETX = 3'd1, PH_CNVX = 3'd2, PH_SETY = 3'd3,
    PH_CNVY = 3'd4, PH_POST = 3'd5, PH_TDET = 3'd6, PH_UPD = 3'd7
  } ph_t;

  ph_t st, st_n;
  logic en, pwr, irq4;
  logic [2:0] res_x, res_y;
  logic [DLY_W-1:0] d_setl, d_post, d_tdet, d_upd, lim, tmr;
  logic tmr_done, ovr;
  logic [9:0] x_q;
  logic [31:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic unused_bits;

  assign unused_bits = ^{reg_wdata, pwr};

  always_comb begin
    case (st)
      PH_SETX, PH_SETY: lim = d_setl;
      PH_POST:          lim = d_post;
      PH_TDET:          lim = d_tdet;
      default:          lim = d_upd;
    endcase
  end

  assign tmr_done = ({1'b0, tmr} + (DLY_W+1)'(1)) >= {1'b0, lim};

  always_comb begin
    st_n = st;
    case (st)
      PH_OFF:  if (en)       st_n = PH_SETX;
      PH_SETX: if (tmr_done) st_n = en ? PH_CNVX : PH_OFF;
      PH_CNVX: if (adc_ack)  st_n = en ? PH_SETY : PH_OFF;
      PH_SETY: if (tmr_done) st_n = en ? PH_CNVY : PH_OFF;
      PH_CNVY: if (adc_ack)  st_n = en ? PH_POST : PH_OFF;
      PH_POST: if (tmr_done) st_n = en ? PH_TDET : PH_OFF;
      PH_TDET: if (tmr_done) st_n = en ? PH_UPD  : PH_OFF;
      PH_UPD:  if (tmr_done) st_n = en ? PH_SETX : PH_OFF;
      default:               st_n = PH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PH_OFF;
      tmr <= '0;
    end else begin
      st  <= st_n;
      tmr <= (st_n != st) ? '0 : tmr + DLY_W'(1);
    end
  end

  assign adc_req    = (st == PH_CNVX) || (st == PH_CNVY);
  assign adc_chan_y = (st == PH_CNVY);
  assign phase      = st;

  wire [9:0] mask_x = 10'h3FF << res_x;
  wire [9:0] mask_y = 10'h3FF << res_y;
  wire take_x  = (st == PH_CNVX) && adc_ack;
  wire push_ev = (st == PH_CNVY) && adc_ack;
  wire pop     = reg_rd && (reg_addr == A_FIFO) && (cnt != '0);
  wire full    = (cnt == FULL_CNT);
  wire push_ok = push_ev && (!full || pop);
  wire drop    = push_ev && full && !pop;
  wire [31:0] word = {~pen_down, 5'd0, x_q, 6'd0, adc_data & mask_y};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) x_q <= '0;
    else if (take_x) x_q <= adc_data & mask_x;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovr <= 1'b0;
    end else begin
      if (push_ok) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)     rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      cnt <= cnt + CW'(push_ok) - CW'(pop);
      if (drop) ovr <= 1'b1;
      else if (reg_rd && reg_addr == A_STAT) ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      pwr    <= 1'b0;
      irq4   <= 1'b0;
      res_x  <= '0;
      res_y  <= '0;
      d_setl <= DLY_W'(RST_SETL);
      d_post <= DLY_W'(RST_POST);
      d_tdet <= DLY_W'(RST_TDET);
      d_upd  <= DLY_W'(RST_UPD);
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL: begin
          en    <= reg_wdata[0];
          pwr   <= reg_wdata[2];
          res_y <= reg_wdata[6:4];
          res_x <= reg_wdata[9:7];
          irq4  <= reg_wdata[11];
        end
        A_SETL: d_setl <= reg_wdata[DLY_W-1:0];
        A_POST: d_post <= reg_wdata[DLY_W-1:0];
        A_TDET: d_tdet <= reg_wdata[DLY_W-1:0];
        A_UPD:  d_upd  <= reg_wdata[DLY_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT: begin
        reg_rdata[8] = ovr;
        reg_rdata[7] = (cnt == '0);
      end
      A_CTRL: reg_rdata[11:0] = {irq4, 1'b0, res_x, res_y, 1'b0, pwr, 1'b0, en};
      A_FIFO: if (cnt != '0) reg_rdata = mem[rp];
      A_SETL: reg_rdata[DLY_W-1:0] = d_setl;
      A_POST: reg_rdata[DLY_W-1:0] = d_post;
      A_TDET: reg_rdata[DLY_W-1:0] = d_tdet;
      A_UPD:  reg_rdata[DLY_W-1:0] = d_upd;
      default: ;
    endcase
  end

  assign irq = irq4 ? (cnt >= IRQ4_CNT) : (cnt != '0);
endmodule

// File: rtl/tsc_autoscan_chk.sv
`timescale 1ns/1ps
module tsc_autoscan_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    phase,
  input logic          adc_req,
  input logic          adc_ack,
  input logic          adc_chan_y,
  input logic          reg_rd,
  input logic [2:0]    reg_addr,
  input logic          en,
  input logic          ovr,
  input logic [CW-1:0] cnt
);
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && !adc_ack) |=> (adc_req && $stable(adc_chan_y)));

  a_r8_overrun_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && adc_ack && adc_chan_y && cnt == CW'(DEPTH) && !(reg_rd && reg_addr == 3'd2)) |=> ovr);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r10_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && phase == 3'd0) |=> (phase == 3'd0 && !adc_req));

  a_r2_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |->
      (phase == 3'd0 || phase == $past(phase) + 3'd1 || ($past(phase) == 3'd7 && phase == 3'd1)));
endmodule

bind tsc_autoscan tsc_autoscan_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .adc_req(adc_req), .adc_ack(adc_ack),
  .adc_chan_y(adc_chan_y), .reg_rd(reg_rd), .reg_addr(reg_addr), .en(en),
  .ovr(ovr), .cnt(cnt)
);

// File: tb/tsc_autoscan_test.sv
`timescale 1ns/1ps
module tsc_autoscan_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr, reg_rd;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic adc_req, adc_chan_y, adc_ack, pen_down, irq;
  logic [9:0] adc_data;
  logic [2:0] phase;

  always #2.5 clk = ~clk;

  tsc_autoscan uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_req(adc_req), .adc_chan_y(adc_chan_y),
    .adc_ack(adc_ack), .adc_data(adc_data), .pen_down(pen_down), .phase(phase), .irq(irq)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [31:0] mq[$];
  bit movr = 0, irq4_m = 0, push_f = 0;
  logic [31:0] push_w;
  int S = 2, A = 4, T = 16, I = 88, rx = 0, ry = 0;
  int last_chan = 0, last_t = 0, wl = 0;
  bit seen = 0;
  logic [9:0] lastx = '0;

  function automatic int lim(int v); return (v == 0) ? 1 : v; endfunction
  function automatic logic [9:0] mk(int n); return 10'h3FF << n; endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference queue, updated at the edge: pop first, then push
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (reg_rd && reg_addr == 3'd2 && mq.size() > 0) void'(mq.pop_front());
      if (reg_rd && reg_addr == 3'd0) movr = 0;
      if (push_f) begin
        if (mq.size() < 4) mq.push_back(push_w);
        else movr = 1;
      end
      if (reg_wr && reg_addr == 3'd1) irq4_m = reg_wdata[11];
    end
  end

  // converter model and handshake timing
  initial begin
    adc_ack = 0; adc_data = '0; pen_down = 0;
    forever begin
      @(negedge clk);
      push_f = 0;
      if (adc_ack) adc_ack = 0;
      else if (adc_req) begin
        if (!seen) begin
          seen = 1;
          wl = $urandom % 3;
          if (last_chan == 1) begin
            chk(adc_chan_y == 1, "R4 Y follows X", 32'(adc_chan_y), 1);
            chk(cyc - last_t == lim(S), "R3 settle gap", cyc - last_t, lim(S));
          end else if (last_chan == 2) begin
            chk(adc_chan_y == 0, "R4 X follows Y", 32'(adc_chan_y), 0);
            chk(cyc - last_t == lim(A) + lim(T) + lim(I) + lim(S), "R3 frame gap",
                cyc - last_t, lim(A) + lim(T) + lim(I) + lim(S));
          end
          if (!adc_chan_y) pen_down = ($urandom % 4) != 0;
        end
        if (wl == 0) begin
          adc_ack = 1;
          adc_data = 10'($urandom);
          seen = 0;
          last_t = cyc + 1;
          if (!adc_chan_y) begin
            lastx = adc_data & mk(rx);
            last_chan = 1;
          end else begin
            push_w = {~pen_down, 5'd0, lastx, 6'd0, adc_data & mk(ry)};
            push_f = 1;
            last_chan = 2;
          end
        end else wl--;
      end
    end
  end

  // phase order and interrupt level
  initial begin
    logic [2:0] prev;
    bit iexp;
    prev = 3'd0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (phase != prev)
        chk(phase == 3'd0 || phase == prev + 3'd1 || (prev == 3'd7 && phase == 3'd1),
            "R2 phase order", 32'(phase), 32'(prev + 3'd1));
      prev = phase;
      iexp = irq4_m ? (mq.size() >= 4) : (mq.size() >= 1);
      chk(irq == iexp, "R9 irq level", 32'(irq), 32'(iexp));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_rd = 0; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic reg_chk(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 chk(reg_rdata == e, tag, reg_rdata, e);
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic fifo_rd(input string tag);
    logic [31:0] e;
    @(negedge clk);
    reg_rd = 1; reg_addr = 3'd2;
    #1 e = (mq.size() > 0) ? mq[0] : 32'd0;
    chk(reg_rdata == e, tag, reg_rdata, e);
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic stat_rd(output logic [31:0] v);
    logic [31:0] e;
    @(negedge clk);
    reg_rd = 1; reg_addr = 3'd0;
    #1 e = {23'd0, movr, mq.size() == 0, 7'd0};
    v = reg_rdata;
    chk(v == e, "R7 R8 status word", v, e);
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic start(input int s, a, t, i, x, y, input bit i4);
    S = s; A = a; T = t; I = i; rx = x; ry = y;
    wr(3'd3, 32'(s)); wr(3'd4, 32'(a)); wr(3'd5, 32'(t)); wr(3'd6, 32'(i));
    last_chan = 0;
    wr(3'd1, (32'(i4) << 11) | (32'(x) << 7) | (32'(y) << 4) | 32'h5);
  endtask

  task automatic stop_and_drain();
    logic [31:0] v;
    int bad;
    wr(3'd1, (32'(irq4_m) << 11) | (32'(rx) << 7) | (32'(ry) << 4));
    for (int k = 0; k < 600 && phase != 3'd0; k++) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (adc_req || phase != 3'd0) bad++;
    end
    chk(bad == 0, "R10 idle after stop", 32'(bad), 0);
    stat_rd(v);
    while (mq.size() > 0) fifo_rd("R10 queue kept after stop");
    stat_rd(v);
    chk(v[7] == 1'b1, "R7 empty after drain", 32'(v[7]), 1);
  endtask

  task automatic run(input int n);
    logic [31:0] v;
    for (int k = 0; k < n; k++) begin
      int c = $urandom % 6;
      if (c == 0) fifo_rd("R5 R6 R7 queue word");
      else if (c == 1) stat_rd(v);
      else @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(phase == 3'd0 && !adc_req && !irq, "R1 outputs idle", {phase, adc_req, irq}, 0);
    reg_chk(3'd0, 32'h80, "R1 status reset");
    reg_chk(3'd1, 32'h0, "R1 control reset");
    reg_chk(3'd3, 32'd2, "R1 settle reset");
    reg_chk(3'd4, 32'd4, "R1 post reset");
    reg_chk(3'd5, 32'd16, "R1 touch reset");
    reg_chk(3'd6, 32'd88, "R1 update reset");

    wr(3'd1, 32'hFFFF_FFFE);
    reg_chk(3'd1, 32'h0000_0BF4, "R11 control readback");
    wr(3'd1, 32'h0);
    reg_chk(3'd1, 32'h0, "R11 control cleared");
    fifo_rd("R7 empty read gives 0");
    reg_chk(3'd0, 32'h80, "R7 empty read no effect");

    start(2, 4, 16, 88, 0, 0, 0);
    run(800);
    stop_and_drain();

    start(0, 0, 0, 0, 2, 5, 0);
    run(300);
    stop_and_drain();

    for (int r = 0; r < 5; r++) begin
      start($urandom % 5, $urandom % 5, $urandom % 5, $urandom % 5,
            $urandom % 8, $urandom % 8, 1'($urandom % 2));
      run(400);
      stop_and_drain();
    end

    // overrun corner: no reads until a sample is dropped
    start(1, 1, 1, 1, 0, 0, 1);
    for (int k = 0; k < 3000 && !movr; k++) @(negedge clk);
    wr(3'd1, 32'h800);
    for (int k = 0; k < 600 && phase != 3'd0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R9 irq at four queued", 32'(irq), 1);
    stat_rd(v);
    chk(v[8] == 1'b1, "R8 overrun latched", 32'(v[8]), 1);
    stat_rd(v);
    chk(v[8] == 1'b0, "R8 overrun cleared by status read", 32'(v[8]), 0);
    for (int k = 0; k < 4; k++) fifo_rd("R8 stored words intact");
    fifo_rd("R7 empty read after drain");
    stat_rd(v);
    chk(v[7] == 1'b1, "R7 empty flag", 32'(v[7]), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule